// File: doc/BRIEF.md
# APB3 Mixed-Type Register Bank

This block is an APB3 slave that places several register kinds into one 32-bit, word-addressed space. Software sees a read-write control field, a write-only field, an 80-bit register that spans three consecutive words, and a write-triggered pulse output that carries the written value for one cycle. It also sees a read port onto an incoming valid/ready stream, where one read returns the stream's valid flag and payload and also takes the item. Finally there is a sticky event word that gathers event bits on every clock and empties when it is read.

Register actions take place only in the APB access phase, when PSEL and PENABLE are both high. The slave never inserts wait states and never signals an error. All storage clears on the active-low reset. Bits 1:0 of the byte address are ignored. Any address not listed below reads as zero, and writes to it have no effect.

Top module: `apb_mixed_regbank`

## Requirements
- R1: After reset, ctrl_o, wo_o and wide_o are zero, flow_valid_o and strm_ready_o are low, and reads of 0x00, 0x08, 0x0C, 0x10 and 0x1C (with no events arriving) return zero.
- R2: Address 0x00 is read-write. A write loads PWDATA[11:4] into ctrl_o. A read returns ctrl_o in bits 11:4, and every other bit reads as zero.
- R3: Address 0x04 is write-only. A write loads PWDATA[19:8] into wo_o. A read returns zero. wo_o keeps its value in every cycle that has no access-phase write to 0x04.
- R4: The 80-bit register wide_o occupies 0x08 (bits 31:0), 0x0C (bits 63:32) and 0x10 (bits 79:64 in PWDATA/PRDATA[15:0]). Each word is read-write, and bits 31:16 of 0x10 read as zero.
- R5: During an access-phase write to 0x14, flow_valid_o is high and flow_data_o equals PWDATA[15:0]. flow_valid_o is low in every other cycle, and a read of 0x14 returns zero.
- R6: A read of 0x18 returns the stream valid in bit 31 and the payload in bits 15:0, with all other bits zero. strm_ready_o is high only during the access phase of a read of 0x18, so exactly one pending item is taken per such read.
- R7: A read of 0x18 while strm_valid_i is low returns all zeros and no stream item is transferred.
- R8: The event word at 0x1C holds bits 7:0. On every clock each bit set in evt_i is ORed in, and no set bit drops except through a read of 0x1C.
- R9: A read of 0x1C returns the value held before the read, then clears the word. Any evt_i bit present in that same cycle is kept in the word after the clear.
- R10: PREADY is always 1 and PSLVERR always 0. A setup-phase cycle alone (PSEL high, PENABLE low) changes no register and produces no pulse.
- R11: Reads of unmapped addresses (0x20 and above) return zero, and writes to them leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address; bits 1:0 ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ctrl_o | output | 8 | Read-write control field |
| wo_o | output | 12 | Write-only field |
| wide_o | output | 80 | Three-word register |
| flow_valid_o | output | 1 | One-cycle pulse on write to 0x14 |
| flow_data_o | output | 16 | Value carried with the pulse |
| strm_valid_i | input | 1 | Incoming stream valid |
| strm_data_i | input | 16 | Incoming stream payload |
| strm_ready_o | output | 1 | Stream accept, high for the read cycle |
| evt_i | input | 8 | Event bits to accumulate |

## Verification
The sticky event word can be read and cleared in the same cycle in which new event bits arrive. R9 requires that the read returns the older value and that the new bits survive the clear. The bench provokes this collision with directed reads of 0x1C that drive chosen event bits in the access phase. It also drives random events during every random bus transfer. A bench-side model of the accumulate-and-clear rule predicts each read of 0x1C, and that prediction is compared with PRDATA. The stream port is judged the same way: a count of valid/ready handshakes is compared against the number of reads of 0x18 that found an item present.

// File: rtl/apb_mixed_regbank.sv
module apb_mixed_regbank #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CTRL_W      = 8,
  parameter int CTRL_OFS    = 4,
  parameter int CTRL_ADDR   = 'h00,
  parameter int WO_W        = 12,
  parameter int WO_OFS      = 8,
  parameter int WO_ADDR     = 'h04,
  parameter int WIDE_W      = 80,
  parameter int WIDE_ADDR   = 'h08,
  parameter int FLOW_W      = 16,
  parameter int FLOW_OFS    = 0,
  parameter int FLOW_ADDR   = 'h14,
  parameter int STR_W       = 16,
  parameter int STR_OFS     = 0,
  parameter int STR_VLD_BIT = 31,
  parameter int STR_ADDR    = 'h18,
  parameter int EVT_W       = 8,
  parameter int EVT_OFS     = 0,
  parameter int EVT_ADDR    = 'h1C
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [WO_W-1:0]   wo_o,
  output logic [WIDE_W-1:0] wide_o,
  output logic              flow_valid_o,
  output logic [FLOW_W-1:0] flow_data_o,
  input  logic              strm_valid_i,
  input  logic [STR_W-1:0]  strm_data_i,
  output logic              strm_ready_o,
  input  logic [EVT_W-1:0]  evt_i
);

  localparam int WORD_LSB   = $clog2(DATA_W / 8);
  localparam int WA_W       = ADDR_W - WORD_LSB;
  localparam int WIDE_WORDS = (WIDE_W + DATA_W - 1) / DATA_W;
  localparam int WIDE_PAD   = WIDE_WORDS * DATA_W;
  localparam int WIDE_IDX   = WIDE_ADDR >> WORD_LSB;
  localparam logic [WA_W-1:0] CTRL_IDX = WA_W'(CTRL_ADDR >> WORD_LSB);
  localparam logic [WA_W-1:0] WO_IDX   = WA_W'(WO_ADDR >> WORD_LSB);
  localparam logic [WA_W-1:0] FLOW_IDX = WA_W'(FLOW_ADDR >> WORD_LSB);
  localparam logic [WA_W-1:0] STR_IDX  = WA_W'(STR_ADDR >> WORD_LSB);
  localparam logic [WA_W-1:0] EVT_IDX  = WA_W'(EVT_ADDR >> WORD_LSB);

  logic [WA_W-1:0]   widx;
  logic              wr_acc, rd_acc;
  logic [CTRL_W-1:0] ctrl_q;
  logic [WO_W-1:0]   wo_q;
  logic [EVT_W-1:0]  evt_q;
  logic [DATA_W-1:0] wide_w [WIDE_WORDS];
  logic [WIDE_PAD-1:0] wide_cat;
  logic              unused_lsb;

  assign widx       = paddr[ADDR_W-1:WORD_LSB];
  assign unused_lsb = ^paddr[WORD_LSB-1:0];
  assign wr_acc     = psel & penable & pwrite;
  assign rd_acc     = psel & penable & ~pwrite;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)                       ctrl_q <= '0;
    else if (wr_acc && widx == CTRL_IDX) ctrl_q <= pwdata[CTRL_OFS +: CTRL_W];

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)                     wo_q <= '0;
    else if (wr_acc && widx == WO_IDX) wo_q <= pwdata[WO_OFS +: WO_W];

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      for (int k = 0; k < WIDE_WORDS; k++) wide_w[k] <= '0;
    end else if (wr_acc) begin
      for (int k = 0; k < WIDE_WORDS; k++)
        if (widx == WA_W'(WIDE_IDX + k)) wide_w[k] <= pwdata;
    end

  always_comb
    for (int k = 0; k < WIDE_WORDS; k++) wide_cat[k*DATA_W +: DATA_W] = wide_w[k];

  // a clearing read reloads with this cycle's events so none is lost
  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)                       evt_q <= '0;
    else if (rd_acc && widx == EVT_IDX) evt_q <= evt_i;
    else                                evt_q <= evt_q | evt_i;

  assign flow_valid_o = wr_acc && widx == FLOW_IDX;
  assign flow_data_o  = pwdata[FLOW_OFS +: FLOW_W];
  assign strm_ready_o = rd_acc && widx == STR_IDX;

  assign ctrl_o = ctrl_q;
  assign wo_o   = wo_q;
  assign wide_o = wide_cat[WIDE_W-1:0];

  always_comb begin
    prdata = '0;
    if (widx == CTRL_IDX) prdata[CTRL_OFS +: CTRL_W] = ctrl_q;
    if (widx == EVT_IDX)  prdata[EVT_OFS +: EVT_W]   = evt_q;
    if (widx == STR_IDX) begin
      prdata[STR_VLD_BIT] = strm_valid_i;
      if (strm_valid_i) prdata[STR_OFS +: STR_W] = strm_data_i;
    end
    for (int k = 0; k < WIDE_WORDS; k++)
      if (widx == WA_W'(WIDE_IDX + k))
        prdata = (WIDE_PAD'(wide_o) >> (k * DATA_W)) & {DATA_W{1'b1}};
  end

endmodule

// File: rtl/apb_mixed_regbank_chk.sv
module apb_mixed_regbank_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CTRL_W    = 8,
  parameter int CTRL_ADDR = 'h00,
  parameter int WO_W      = 12,
  parameter int WO_ADDR   = 'h04,
  parameter int WIDE_W    = 80,
  parameter int WIDE_ADDR = 'h08,
  parameter int STR_ADDR  = 'h18,
  parameter int EVT_W     = 8,
  parameter int EVT_ADDR  = 'h1C
) (
  input logic                                   pclk,
  input logic                                   presetn,
  input logic                                   psel,
  input logic                                   penable,
  input logic                                   pwrite,
  input logic [ADDR_W-$clog2(DATA_W/8)-1:0]     widx,
  input logic [DATA_W-1:0]                      prdata,
  input logic                                   pready,
  input logic                                   pslverr,
  input logic [CTRL_W-1:0]                      ctrl_o,
  input logic [WO_W-1:0]                        wo_o,
  input logic                                   flow_valid_o,
  input logic                                   strm_ready_o,
  input logic [EVT_W-1:0]                       evt_q,
  input logic [EVT_W-1:0]                       evt_i
);
  localparam int LSB   = $clog2(DATA_W / 8);
  localparam int WORDS = (WIDE_W + DATA_W - 1) / DATA_W;

  logic readable, clr_rd, wo_wr;
  assign readable = int'(widx) == (CTRL_ADDR >> LSB) || int'(widx) == (STR_ADDR >> LSB) ||
                    int'(widx) == (EVT_ADDR >> LSB) ||
                    (int'(widx) >= (WIDE_ADDR >> LSB) && int'(widx) < (WIDE_ADDR >> LSB) + WORDS);
  assign clr_rd = psel && penable && !pwrite && int'(widx) == (EVT_ADDR >> LSB);
  assign wo_wr  = psel && penable && pwrite && int'(widx) == (WO_ADDR >> LSB);

  AST_BUS_OK:        assert property (@(posedge pclk) disable iff (!presetn) pready && !pslverr); // R10
  AST_SETUP_QUIET:   assert property (@(posedge pclk) disable iff (!presetn) (psel && !penable) |=> $stable(ctrl_o)); // R10
  AST_FLOW_ACCESS:   assert property (@(posedge pclk) disable iff (!presetn) flow_valid_o |-> psel && penable && pwrite); // R5
  AST_FLOW_SINGLE:   assert property (@(posedge pclk) disable iff (!presetn) flow_valid_o |=> !flow_valid_o); // R5
  AST_READY_ACCESS:  assert property (@(posedge pclk) disable iff (!presetn) strm_ready_o |-> psel && penable && !pwrite); // R6
  AST_WO_HOLD:       assert property (@(posedge pclk) disable iff (!presetn) !wo_wr |=> $stable(wo_o)); // R3
  AST_EVT_NO_DROP:   assert property (@(posedge pclk) disable iff (!presetn) !clr_rd |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R8
  AST_EVT_CLEAR:     assert property (@(posedge pclk) disable iff (!presetn) clr_rd |=> evt_q == $past(evt_i)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn) (psel && !pwrite && !readable) |-> prdata == '0); // R11
endmodule

bind apb_mixed_regbank apb_mixed_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .CTRL_ADDR(CTRL_ADDR),
  .WO_W(WO_W), .WO_ADDR(WO_ADDR), .WIDE_W(WIDE_W), .WIDE_ADDR(WIDE_ADDR),
  .STR_ADDR(STR_ADDR), .EVT_W(EVT_W), .EVT_ADDR(EVT_ADDR)
) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .widx(widx), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .ctrl_o(ctrl_o), .wo_o(wo_o), .flow_valid_o(flow_valid_o),
  .strm_ready_o(strm_ready_o), .evt_q(evt_q), .evt_i(evt_i)
);

// File: tb/apb_mixed_regbank_tb.sv
module apb_mixed_regbank_tb;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  ctrl_o;
  logic [11:0] wo_o;
  logic [79:0] wide_o;
  logic        flow_valid_o;
  logic [15:0] flow_data_o;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        strm_ready_o;
  logic [7:0]  evt_i = '0;

  int vecs = 0, errs = 0, pops = 0, exp_pops = 0;
  logic [7:0]  m_ctrl = '0, m_evt = '0;
  logic [11:0] m_wo = '0;
  logic [79:0] m_wide = '0;

  always #10 pclk = ~pclk;

  apb_mixed_regbank u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .ctrl_o(ctrl_o), .wo_o(wo_o), .wide_o(wide_o), .flow_valid_o(flow_valid_o),
    .flow_data_o(flow_data_o), .strm_valid_i(s_valid), .strm_data_i(s_data),
    .strm_ready_o(strm_ready_o), .evt_i(evt_i)
  );

  // event word model: OR in every cycle, reload with new events on a read of 0x1C
  always @(posedge pclk)
    if (!presetn) m_evt <= '0;
    else if (psel && penable && !pwrite && paddr[7:2] == 6'd7) m_evt <= evt_i;
    else m_evt <= m_evt | evt_i;

  always @(posedge pclk)
    if (presetn && strm_ready_o && s_valid) pops <= pops + 1;

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a[7:2])
      6'd0: return {20'b0, m_ctrl, 4'b0};
      6'd2: return m_wide[31:0];
      6'd3: return m_wide[63:32];
      6'd4: return {16'b0, m_wide[79:64]};
      6'd6: return {s_valid, 15'b0, s_valid ? s_data : 16'h0};
      6'd7: return {24'b0, m_evt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
    case (a[7:2])
      6'd0: m_ctrl = d[11:4];
      6'd1: m_wo = d[19:8];
      6'd2: m_wide[31:0] = d;
      6'd3: m_wide[63:32] = d;
      6'd4: m_wide[79:64] = d[15:0];
      default: ;
    endcase
  endtask

  task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [7:0] ev_setup, input logic [7:0] ev_acc);
    logic [31:0] exp;
    logic        took;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; evt_i = ev_setup;
    @(negedge pclk);
    chk("R10 setup no pulse", {flow_valid_o, strm_ready_o}, 2'b00);
    penable = 1'b1; evt_i = ev_acc;
    #1;
    chk("R10 bus status", {pready, pslverr}, 2'b10);
    chk("R5 flow valid", flow_valid_o, wr && a[7:2] == 6'd5);
    if (wr && a[7:2] == 6'd5) chk("R5 flow data", flow_data_o, d[15:0]);
    chk("R6 ready", strm_ready_o, !wr && a[7:2] == 6'd6);
    exp  = exp_rd(a);
    took = !wr && a[7:2] == 6'd6 && s_valid;
    if (!wr) begin
      if (a[7:2] == 6'd7)                     chk("R9 event read", prdata, exp);
      else if (a[7:2] == 6'd6 && !s_valid)    chk("R7 empty stream read", prdata, exp);
      else if (a[7:2] == 6'd6)                chk("R6 stream read", prdata, exp);
      else if (a[7:2] >= 6'd8 || a[7:2] == 6'd1 || a[7:2] == 6'd5)
                                              chk("R11 R3 zero read", prdata, exp);
      else                                    chk("R2 R4 register read", prdata, exp);
    end
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; evt_i = '0;
    if (wr) model_wr(a, d);
    if (took) begin
      exp_pops++;
      s_valid = 1'($urandom % 2); s_data = 16'($urandom);
    end
    #1;
    chk("R2 ctrl_o", ctrl_o, m_ctrl);
    chk("R3 wo_o", wo_o, m_wo);
    chk("R4 wide_o", wide_o, m_wide);
    chk("R5 flow idle", flow_valid_o, 1'b0);
    chk("R6 R7 handshakes", pops, exp_pops);
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    // R1 reset state
    chk("R1 outputs", {ctrl_o, wo_o, wide_o}, '0);
    chk("R1 strobes", {flow_valid_o, strm_ready_o}, 2'b00);
    bus(0, 8'h00, 0, 0, 0);
    bus(0, 8'h0C, 0, 0, 0);
    bus(0, 8'h1C, 0, 0, 0);

    // R2 field placement
    bus(1, 8'h00, 32'hFFFF_FFFF, 0, 0);
    bus(0, 8'h00, 0, 0, 0);
    chk("R2 field only", ctrl_o, 8'hFF);
    // R3 write-only
    bus(1, 8'h04, 32'hFFFF_FFFF, 0, 0);
    chk("R3 wo loaded", wo_o, 12'hFFF);
    bus(1, 8'h00, 32'h0000_0A50, 0, 0);
    chk("R3 wo held", wo_o, 12'hFFF);
    bus(0, 8'h04, 0, 0, 0);
    // R4 wide register, low word first
    bus(1, 8'h08, 32'h1111_1111, 0, 0);
    bus(1, 8'h0C, 32'h2222_2222, 0, 0);
    bus(1, 8'h10, 32'hFFFF_FFFF, 0, 0);
    chk("R4 wide order", wide_o, 80'hFFFF_2222_2222_1111_1111);
    bus(0, 8'h10, 0, 0, 0);
    // R5 flow pulse
    bus(1, 8'h14, 32'hABCD_1234, 0, 0);
    bus(0, 8'h14, 0, 0, 0);
    // R6 stream item taken
    s_valid = 1'b1; s_data = 16'h5A5A;
    bus(0, 8'h18, 0, 0, 0);
    // R7 empty stream read
    s_valid = 1'b0; s_data = 16'hFFFF;
    bus(0, 8'h18, 0, 0, 0);
    chk("R7 nothing taken", pops, exp_pops);
    // R8 accumulation over separate cycles
    bus(1, 8'h40, 0, 8'h01, 8'h10);
    bus(1, 8'h44, 0, 8'h02, 8'h00);
    bus(0, 8'h1C, 0, 8'h00, 8'h00);
    // R9 event in the clearing cycle survives
    bus(1, 8'h40, 0, 8'h0C, 8'h00);
    bus(0, 8'h1C, 0, 8'h00, 8'h81);
    bus(0, 8'h1C, 0, 8'h00, 8'h00);
    bus(0, 8'h1C, 0, 8'h00, 8'h00);
    // R10 setup phase alone does nothing
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0000_0000;
    @(negedge pclk);
    paddr = 8'h14;
    @(negedge pclk);
    psel = 1'b0;
    chk("R10 setup only ctrl", ctrl_o, m_ctrl);
    chk("R10 setup only flow", flow_valid_o, 1'b0);
    @(negedge pclk);
    // R11 unmapped writes and reads
    bus(1, 8'h20, 32'hFFFF_FFFF, 0, 0);
    bus(1, 8'hFC, 32'hFFFF_FFFF, 0, 0);
    bus(0, 8'h20, 0, 0, 0);
    bus(0, 8'hFC, 0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic [7:0] e1, e2;
      a  = {2'b0, 4'($urandom % 12), 2'b00};
      e1 = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
      e2 = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
      if (!s_valid && $urandom % 3 == 0) begin
        s_valid = 1'b1; s_data = 16'($urandom);
      end
      case ($urandom % 4)
        0: bus(1, a, $urandom, e1, e2);
        1: bus(0, a, 0, e1, e2);
        2: bus(0, 8'h18, 0, e1, e2);
        default: bus(0, 8'h1C, 0, e1, e2);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule